// File: doc/BRIEF.md
# Regulator Output Protection Supervisor

This block supervises the output of a multiphase voltage regulator from digitized measurements. Each clock it takes millivolt codes for the sensed output, the feedback-return node, the programmed reference and the controller supply. It also takes an output-enable input and a flag that is high while the reference is being moved to a new target. From these it drives a latched undervoltage fault, a command that turns every power switch off, a low-side-on command for early overvoltage clamping, and a status bit that shows when protections are masked.

The supply code divides operation into three regions. Below the clamp threshold (3000 mV) nothing is protected and every output is low. Between the clamp threshold and the turn-on threshold (4500 mV), only the hysteretic early clamp on the feedback-return node is active. At or above turn-on, with the output enabled, the undervoltage monitor runs. The monitor is suppressed while the reference moves and for a fixed tail of 32 clocks afterwards, so that a moving target does not cause a false trip. Soft-start does not mask anything. All thresholds are parameters, and no mode setting changes the response.

Top module: `svp_supervisor`

## Requirements
- R1: While vcc_mv is below 3000, after the next clock edge uv_fault, all_off, ls_on and prot_mask are all 0, even if ref_flag is 1 or fbr_mv is high.
- R2: With vcc_mv at least 4500, out_en 1 and no mask, uv_fault rises after the second of two consecutive edges at which vsen_mv + 750 < vref_mv. A dip lasting a single edge, or a gap of exactly 750 mV, does not set it.
- R3: Once set, uv_fault stays 1 while out_en is 1 and vcc_mv is at least 4500, whatever vsen_mv does.
- R4: uv_fault clears at the edge that samples out_en low or vcc_mv below 4500. Monitoring starts again from a fresh persistence count.
- R5: all_off equals uv_fault in every cycle.
- R6: prot_mask is 1 after an edge that samples ref_flag high, and it stays 1 for 32 further edges after ref_flag is sampled low. While it is 1, undervoltage samples neither set the fault nor count toward the persistence count.
- R7: A new ref_flag pulse during the tail restarts the full 32-edge tail.
- R8: With vcc_mv in [3000, 4500), ls_on becomes 1 after an edge at which fbr_mv > 1800. A value of exactly 1800 does not set it.
- R9: Once set, ls_on stays 1 while fbr_mv is in [1450, 1800]. It clears after an edge at which fbr_mv < 1450.
- R10: The clamp ignores out_en and the mask, and ls_on is 0 whenever vcc_mv is at or above 4500.
- R11: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsen_mv | input | 16 | Sensed output voltage, mV |
| fbr_mv | input | 16 | Feedback-return voltage, mV |
| vref_mv | input | 16 | Programmed reference, mV |
| vcc_mv | input | 16 | Controller supply, mV |
| out_en | input | 1 | Output enable |
| ref_flag | input | 1 | Reference transition in progress |
| uv_fault | output | 1 | Latched undervoltage fault |
| all_off | output | 1 | Turn all switches off |
| ls_on | output | 1 | Early-clamp low-side-on command |
| prot_mask | output | 1 | Protections currently masked |

## Verification
A persistence counter that fails to clear would show as uv_fault rising one edge after an isolated dip. A counter that clears too eagerly would hold the fault off past the second low sample. An off-by-one in the mask tail shows at the ports within 33 edges: either prot_mask high for 31 or 33 clocks, or uv_fault rising one edge early or late after a masked undervoltage stretch. A stuck clamp state shows at once as ls_on differing from the hysteresis band at the first sample inside or below it.

// File: rtl/svp_pkg.sv
package svp_pkg;
  typedef enum logic [1:0] {
    SUP_OFF   = 2'd0,
    SUP_CLAMP = 2'd1,
    SUP_RUN   = 2'd2
  } sup_region_e;
endpackage

// File: rtl/svp_mask_timer.sv
module svp_mask_timer #(
  parameter int TAIL = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic slew,
  output logic mask_now,
  output logic mask_q
);
  localparam int CW = $clog2(TAIL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!enable) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (slew) begin
      cnt_d  = CW'(TAIL);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  assign mask_now = enable & (slew | (cnt_q != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      mask_q <= mask_now;
    end
  end
endmodule

// File: rtl/svp_uv_monitor.sv
module svp_uv_monitor #(
  parameter int MV_W      = 16,
  parameter int UV_MARGIN = 750,
  parameter int PERSIST   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            masked,
  input  logic [MV_W-1:0] vsen,
  input  logic [MV_W-1:0] vref,
  output logic            fault
);
  localparam int PW = (PERSIST > 1) ? $clog2(PERSIST) : 1;

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          fault_d;
  logic [MV_W:0] vsen_plus;
  logic          low_cond;

  assign vsen_plus = {1'b0, vsen} + (MV_W+1)'(UV_MARGIN);
  assign low_cond  = run & ~masked & (vsen_plus < {1'b0, vref});

  always_comb begin
    pcnt_d  = pcnt_q;
    fault_d = fault;
    if (!run) begin
      pcnt_d  = '0;
      fault_d = 1'b0;
    end else if (!fault) begin
      if (low_cond) begin
        if (pcnt_q == PW'(PERSIST - 1)) fault_d = 1'b1;
        else                            pcnt_d  = pcnt_q + 1'b1;
      end else begin
        pcnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      fault  <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      fault  <= fault_d;
    end
  end
endmodule

// File: rtl/svp_ovp_clamp.sv
module svp_ovp_clamp #(
  parameter int MV_W   = 16,
  parameter int SET_MV = 1800,
  parameter int REL_MV = 1450
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [MV_W-1:0] fbr,
  output logic            ls_on
);
  logic ls_d;

  always_comb begin
    ls_d = ls_on;
    if (!active)                    ls_d = 1'b0;
    else if (fbr > MV_W'(SET_MV))   ls_d = 1'b1;
    else if (fbr < MV_W'(REL_MV))   ls_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ls_on <= 1'b0;
    else        ls_on <= ls_d;
  end
endmodule

// File: rtl/svp_supervisor.sv
module svp_supervisor #(
  parameter int MV_W         = 16,
  parameter int VCC_CLAMP_MV = 3000,
  parameter int VCC_ON_MV    = 4500,
  parameter int UV_MARGIN    = 750,
  parameter int UV_PERSIST   = 2,
  parameter int MASK_TAIL    = 32,
  parameter int CLAMP_SET_MV = 1800,
  parameter int CLAMP_REL_MV = 1450
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] vsen_mv,
  input  logic [MV_W-1:0] fbr_mv,
  input  logic [MV_W-1:0] vref_mv,
  input  logic [MV_W-1:0] vcc_mv,
  input  logic            out_en,
  input  logic            ref_flag,
  output logic            uv_fault,
  output logic            all_off,
  output logic            ls_on,
  output logic            prot_mask
);
  import svp_pkg::*;

  sup_region_e region;
  logic        mask_now;
  logic        run;

  always_comb begin
    if (vcc_mv < MV_W'(VCC_CLAMP_MV))   region = SUP_OFF;
    else if (vcc_mv < MV_W'(VCC_ON_MV)) region = SUP_CLAMP;
    else                                region = SUP_RUN;
  end

  assign run = (region == SUP_RUN) & out_en;

  svp_mask_timer #(.TAIL(MASK_TAIL)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (region != SUP_OFF),
    .slew     (ref_flag),
    .mask_now (mask_now),
    .mask_q   (prot_mask)
  );

  svp_uv_monitor #(
    .MV_W      (MV_W),
    .UV_MARGIN (UV_MARGIN),
    .PERSIST   (UV_PERSIST)
  ) u_uv (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .masked (mask_now),
    .vsen   (vsen_mv),
    .vref   (vref_mv),
    .fault  (uv_fault)
  );

  svp_ovp_clamp #(
    .MV_W   (MV_W),
    .SET_MV (CLAMP_SET_MV),
    .REL_MV (CLAMP_REL_MV)
  ) u_clamp (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (region == SUP_CLAMP),
    .fbr    (fbr_mv),
    .ls_on  (ls_on)
  );

  assign all_off = uv_fault;
endmodule

// File: rtl/svp_supervisor_chk.sv
module svp_supervisor_chk #(
  parameter int MV_W         = 16,
  parameter int VCC_CLAMP_MV = 3000,
  parameter int VCC_ON_MV    = 4500,
  parameter int UV_MARGIN    = 750,
  parameter int CLAMP_SET_MV = 1800,
  parameter int CLAMP_REL_MV = 1450
) (
  input logic            clk,
  input logic            rst_n,
  input logic [MV_W-1:0] vsen_mv,
  input logic [MV_W-1:0] fbr_mv,
  input logic [MV_W-1:0] vref_mv,
  input logic [MV_W-1:0] vcc_mv,
  input logic            out_en,
  input logic            ref_flag,
  input logic            uv_fault,
  input logic            all_off,
  input logic            ls_on,
  input logic            prot_mask
);
  logic in_run, in_win, in_off, uv_low;
  assign in_off = vcc_mv < MV_W'(VCC_CLAMP_MV);
  assign in_run = vcc_mv >= MV_W'(VCC_ON_MV);
  assign in_win = !in_off && !in_run;
  assign uv_low = ({1'b0, vsen_mv} + (MV_W+1)'(UV_MARGIN)) < {1'b0, vref_mv};

  // R2: a fault only rises after an unmasked low sample in the run region
  a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_fault) |-> $past(uv_low && out_en && in_run && !ref_flag));
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_fault && out_en && in_run) |=> uv_fault);
  a_r4_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en || !in_run) |=> !uv_fault);
  a_r5_off_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(all_off && ls_on));
  a_r6_mask_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_flag && !in_off) |=> prot_mask);
  a_r8_clamp_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && fbr_mv > MV_W'(CLAMP_SET_MV)) |=> ls_on);
  a_r9_clamp_rel: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && fbr_mv < MV_W'(CLAMP_REL_MV)) |=> !ls_on);
  a_r9_clamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && ls_on && fbr_mv >= MV_W'(CLAMP_REL_MV)) |=> ls_on);
  a_r10_run_no_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |=> !ls_on);
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_off |=> (!ls_on && !uv_fault && !prot_mask));
endmodule

bind svp_supervisor svp_supervisor_chk #(
  .MV_W         (MV_W),
  .VCC_CLAMP_MV (VCC_CLAMP_MV),
  .VCC_ON_MV    (VCC_ON_MV),
  .UV_MARGIN    (UV_MARGIN),
  .CLAMP_SET_MV (CLAMP_SET_MV),
  .CLAMP_REL_MV (CLAMP_REL_MV)
) u_chk (.*);

// File: tb/tb_svp_supervisor.sv
module tb_svp_supervisor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] vsen_mv, fbr_mv, vref_mv, vcc_mv;
  logic        out_en, ref_flag;
  logic        uv_fault, all_off, ls_on, prot_mask;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  svp_supervisor dut (.*);

  typedef struct packed {
    logic [15:0] vcc;
    logic [15:0] vsen;
    logic [15:0] vref;
    logic [15:0] fbr;
    logic        en;
    logic        flag;
    logic        e_uv;
    logic        e_ls;
    logic        e_mask;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{16'd5000, 16'd1200, 16'd1200, 16'd1200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},
    '{16'd5000, 16'd400,  16'd1200, 16'd1200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 first low
    '{16'd5000, 16'd1200, 16'd1200, 16'd1200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 single dip
    '{16'd5000, 16'd450,  16'd1200, 16'd1200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 exactly 750
    '{16'd5000, 16'd449,  16'd1200, 16'd1200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2},
    '{16'd5000, 16'd449,  16'd1200, 16'd1200, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2},  // R2 trip
    '{16'd5000, 16'd1200, 16'd1200, 16'd1200, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 latched
    '{16'd5000, 16'd1200, 16'd1200, 16'd1200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 enable low
    '{16'd5000, 16'd1200, 16'd1200, 16'd1200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4},
    '{16'd3500, 16'd0,    16'd1200, 16'd1801, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8 set
    '{16'd3500, 16'd0,    16'd1200, 16'd1500, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 hold, R10 en ignored
    '{16'd3500, 16'd0,    16'd1200, 16'd1449, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 release
    '{16'd3500, 16'd0,    16'd1200, 16'd1800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 edge value
    '{16'd3500, 16'd0,    16'd1200, 16'd1700, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd9},
    '{16'd3500, 16'd0,    16'd1200, 16'd2000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8},
    '{16'd2000, 16'd0,    16'd1200, 16'd2000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 off region
    '{16'd5000, 16'd1200, 16'd1200, 16'd2000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd10}  // R10 run: no clamp
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [15:0] vcc, input logic [15:0] vsen,
                       input logic en, input logic flag);
    vcc_mv = vcc; vsen_mv = vsen; out_en = en; ref_flag = flag;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    rst_n = 1'b0;
    vcc_mv = 16'd5000; vsen_mv = 16'd0; vref_mv = 16'd1200; fbr_mv = 16'd2000;
    out_en = 1'b1; ref_flag = 1'b1;
    step(); step();
    // R11 reset state
    chk("R11 uv", uv_fault, 1'b0);
    chk("R11 off", all_off, 1'b0);
    chk("R11 ls", ls_on, 1'b0);
    chk("R11 mask", prot_mask, 1'b0);
    ref_flag = 1'b0; vsen_mv = 16'd1200; fbr_mv = 16'd1200;
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      vcc_mv = VEC[i].vcc; vsen_mv = VEC[i].vsen; vref_mv = VEC[i].vref;
      fbr_mv = VEC[i].fbr; out_en = VEC[i].en; ref_flag = VEC[i].flag;
      step();
      chk($sformatf("R%0d vec%0d uv", VEC[i].req, i), uv_fault, VEC[i].e_uv);
      chk($sformatf("R5 vec%0d all_off", i), all_off, VEC[i].e_uv);
      chk($sformatf("R%0d vec%0d ls", VEC[i].req, i), ls_on, VEC[i].e_ls);
      chk($sformatf("R%0d vec%0d mask", VEC[i].req, i), prot_mask, VEC[i].e_mask);
    end

    // R6: mask tail of 32 edges, undervoltage held off, then trips two edges later
    fbr_mv = 16'd1200;
    drive(16'd5000, 16'd1200, 1'b1, 1'b1);
    step();
    chk("R6 mask on flag", prot_mask, 1'b1);
    drive(16'd5000, 16'd300, 1'b1, 1'b0);
    for (int m = 1; m <= 34; m++) begin
      step();
      chk($sformatf("R6 tail mask m=%0d", m), prot_mask, (m <= 32));
      chk($sformatf("R6 tail uv m=%0d", m), uv_fault, (m >= 34));
    end

    // R4: supply dip clears latch, monitoring resumes
    drive(16'd4000, 16'd300, 1'b1, 1'b0);
    step();
    chk("R4 supply dip clears", uv_fault, 1'b0);
    drive(16'd5000, 16'd1200, 1'b1, 1'b0);
    step();
    chk("R4 after return", uv_fault, 1'b0);

    // R7: restart of the tail
    ref_flag = 1'b1; step(); ref_flag = 1'b0;
    for (int k = 0; k < 10; k++) step();
    ref_flag = 1'b1; step(); ref_flag = 1'b0;
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (prot_mask) hi++;
    end
    chk($sformatf("R7 restarted tail len %0d", hi), hi == 32, 1'b1);

    // R1: flag in off region leaves mask low
    drive(16'd1000, 16'd1200, 1'b1, 1'b1);
    step();
    chk("R1 flag ignored when off", prot_mask, 1'b0);
    ref_flag = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule